// File: doc/BRIEF.md
# I2C Bus Master With Register Control

This block is a single-master I2C controller run by software through four byte-wide registers: control, status, bit rate and data. Software asks for a bus step (START, repeated START, one byte out or in, STOP) by writing the control register with its done bit set. When a step finishes, the engine records a 5-bit result code in the top of the status register and sets the done bit. An interrupt line follows that bit. SCL and SDA are open-drain: the block pulls a line low by asserting its `*_oe` output and reads the wire back on `*_in`.

The SCL rate comes from an 8-bit divider and a 2-bit prescaler select. Bytes go out MSB first, and the ninth clock carries ACK/NACK. In a read, the enable-ACK bit chooses what the master answers. If the engine releases SDA during a bit it is driving and finds SDA low while SCL is high, it has lost arbitration. It then lets go of both lines and reports that result. While the engine has released SCL and still reads it low, the high half-period is held.

Top module: `i2c_host_engine`

## Requirements
- R1: After reset, control reads 0x00, status reads 0xF8, `irq` is 0, and both `scl_oe` and `sda_oe` are 0.
- R2: Register address 0 is control, 1 is status, 2 is bit rate and 3 is data. Control bits: 7 done, 6 enable-ACK, 5 START request, 4 STOP request, 3 write collision, 2 module enable, 1 reads 0, 0 interrupt enable. Status reads {code[4:0], 0, prescale[1:0]}, and only prescale is writable there. Bit rate reads back what was written.
- R3: One full SCL period during a byte is 16 + 2·rate·M system clocks, where prescale 0,1,2,3 gives M = 1,4,16,64.
- R4: START from an idle bus: SDA falls while SCL is high, then SCL is pulled low, done sets and the code is 0x08.
- R5: START requested while the engine holds the bus gives a repeated START: SDA is released, SCL is released, then SDA falls with SCL high. The code is 0x10.
- R6: The first byte after any START is the address. It goes out MSB first, and SDA changes only while SCL is low. Its bit 0 selects read. Codes are 0x18/0x20 for write and 0x40/0x48 for read, for ACK/NACK seen on the ninth clock.
- R7: A data byte sent in write direction reports 0x28 on ACK and 0x30 on NACK.
- R8: In read direction the engine samples eight bits MSB first into the data register. On the ninth clock it pulls SDA low if enable-ACK is 1, and releases it otherwise. The codes are 0x50 and 0x58.
- R9: A control write with bit 7 = 1 and bit 2 = 1 clears done and launches one step: START if bit 5 is set, else STOP if bit 4 is set, else a byte. A control write with bit 7 = 0 launches nothing. Done sets when a START or byte step ends.
- R10: STOP: with SCL low, SDA is pulled low, then SCL is released, then SDA is released. The STOP request bit then clears by itself, done stays 0 and the code becomes 0xF8.
- R11: Writing data while done is 0 sets the write-collision bit and leaves the data register unchanged. Writing data while done is 1 stores the byte and clears write collision.
- R12: If SDA reads low with SCL high in a bit the master drives released, both lines are released, done sets and the code is 0x38.
- R13: `irq` equals done AND interrupt enable AND module enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| irq | output | 1 | Step-complete interrupt |
| scl_in | input | 1 | SCL wire level |
| sda_in | input | 1 | SDA wire level |
| scl_oe | output | 1 | 1 pulls SCL low |
| sda_oe | output | 1 | 1 pulls SDA low |

## Verification
A behavioural target on the bus acknowledges or refuses according to a per-step setting and returns random bytes in read direction. Random address and data bytes, random ACK/NACK, and random divider and prescaler values tell the four result codes of each direction apart and pin the SCL period formula. Directed cases cover the collision rule, a write without the launch bit, START-over-STOP priority, an address NACK in read direction, the two high prescaler settings, and a second device pulling SDA low in the middle of a byte to force arbitration loss. START and STOP edges are counted on the wires, which shows that no stray condition appears inside a byte.

// File: rtl/i2c_hm_pkg.sv
package i2c_hm_pkg;

    typedef enum logic [3:0] {
        ST_IDLE, ST_STA, ST_HOLD, ST_RS1, ST_RS2,
        ST_BLO, ST_BHI, ST_SP1, ST_SP2, ST_SP3
    } eng_state_t;

    typedef enum logic [1:0] {CMD_NONE, CMD_START, CMD_STOP, CMD_BYTE} eng_cmd_t;

    typedef struct packed {
        logic done_f;
        logic ack_en;
        logic req_start;
        logic req_stop;
        logic wcol;
        logic enable;
        logic rsvd;
        logic irq_en;
    } ctrl_t;

    localparam logic [1:0] RA_CTRL = 2'd0;
    localparam logic [1:0] RA_STAT = 2'd1;
    localparam logic [1:0] RA_RATE = 2'd2;
    localparam logic [1:0] RA_DATA = 2'd3;

    localparam logic [4:0] SC_START   = 5'(8'h08 >> 3);
    localparam logic [4:0] SC_RSTART  = 5'(8'h10 >> 3);
    localparam logic [4:0] SC_AW_ACK  = 5'(8'h18 >> 3);
    localparam logic [4:0] SC_AW_NACK = 5'(8'h20 >> 3);
    localparam logic [4:0] SC_DW_ACK  = 5'(8'h28 >> 3);
    localparam logic [4:0] SC_DW_NACK = 5'(8'h30 >> 3);
    localparam logic [4:0] SC_ARB     = 5'(8'h38 >> 3);
    localparam logic [4:0] SC_AR_ACK  = 5'(8'h40 >> 3);
    localparam logic [4:0] SC_AR_NACK = 5'(8'h48 >> 3);
    localparam logic [4:0] SC_DR_ACK  = 5'(8'h50 >> 3);
    localparam logic [4:0] SC_DR_NACK = 5'(8'h58 >> 3);
    localparam logic [4:0] SC_IDLE    = 5'(8'hF8 >> 3);

    function automatic logic [6:0] psc_mult(input logic [1:0] sel);
        case (sel)
            2'd0:    return 7'd1;
            2'd1:    return 7'd4;
            2'd2:    return 7'd16;
            default: return 7'd64;
        endcase
    endfunction

    function automatic logic [4:0] byte_code(input logic addr, input logic rd, input logic ack);
        if (addr)
            return rd ? (ack ? SC_AR_ACK : SC_AR_NACK) : (ack ? SC_AW_ACK : SC_AW_NACK);
        return rd ? (ack ? SC_DR_ACK : SC_DR_NACK) : (ack ? SC_DW_ACK : SC_DW_NACK);
    endfunction

    // 1 = master pulls SDA low for bit slot idx (8 is the acknowledge slot)
    function automatic logic bit_pull(input logic mtx, input logic [3:0] idx,
                                      input logic msb, input logic ack_en);
        if (idx == 4'd8) return !mtx && ack_en;
        return mtx && !msb;
    endfunction

endpackage

// File: rtl/i2c_hm_timer.sv
module i2c_hm_timer
    import i2c_hm_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             stall,
    input  logic [DIV_W-1:0] div,
    input  logic [1:0]       psc,
    output logic             tick
);
    localparam int CNT_W = DIV_W + 8;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;

    // half SCL period = 8 + div * M cycles
    always_comb lim = CNT_W'(8) + CNT_W'(div) * CNT_W'(psc_mult(psc)) - CNT_W'(1);

    assign tick = run && !stall && (cnt == lim);

    always_ff @(posedge clk) begin
        if (rst || !run || tick)
            cnt <= '0;
        else if (!stall)
            cnt <= cnt + CNT_W'(1);
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R3

endmodule

// File: rtl/i2c_hm_fsm.sv
module i2c_hm_fsm
    import i2c_hm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  eng_cmd_t   cmd,
    input  logic [7:0] tx_byte,
    input  logic       ack_en,
    input  logic       sda_in,
    input  logic       scl_in,
    output logic       run,
    output logic       stall,
    output logic       scl_low,
    output logic       sda_low,
    output logic       done,
    output logic [4:0] code,
    output logic       rx_load,
    output logic [7:0] rx_byte,
    output logic       stop_done
);
    eng_state_t st;
    logic [3:0] idx;
    logic [7:0] sh;
    logic       is_addr, is_rd, rep;
    logic       scl_l, sda_l, sda_q;

    logic mtx, drives, lost;
    assign mtx    = is_addr || !is_rd;
    assign drives = (idx == 4'd8) ? !mtx : mtx;
    assign lost   = (st == ST_BHI) && tick && drives && !sda_l && !sda_in;

    assign run     = (st != ST_IDLE) && (st != ST_HOLD);
    assign stall   = !scl_l && !scl_in;
    assign scl_low = scl_l;
    assign sda_low = sda_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE;  idx <= '0;  sh <= '0;
            is_addr <= 1'b0; is_rd <= 1'b0; rep <= 1'b0;
            scl_l <= 1'b0;  sda_l <= 1'b0; sda_q <= 1'b0;
            done <= 1'b0;   code <= SC_IDLE;
            rx_load <= 1'b0; rx_byte <= '0; stop_done <= 1'b0;
        end else begin
            done <= 1'b0; rx_load <= 1'b0; stop_done <= 1'b0;
            sda_q <= sda_l;  // SDA moves one cycle after SCL
            case (st)
                ST_IDLE: begin
                    if (cmd == CMD_START) begin
                        st <= ST_STA; sda_l <= 1'b1; rep <= 1'b0;
                    end else if (cmd == CMD_STOP) begin
                        stop_done <= 1'b1;
                    end
                end
                ST_HOLD: begin
                    case (cmd)
                        CMD_START: begin st <= ST_RS1; sda_l <= 1'b0; end
                        CMD_STOP:  begin st <= ST_SP1; sda_l <= 1'b1; end
                        CMD_BYTE: begin
                            st  <= ST_BLO;
                            idx <= '0;
                            sh  <= tx_byte;
                            if (is_addr) is_rd <= tx_byte[0];
                            sda_l <= bit_pull(mtx, 4'd0, tx_byte[7], ack_en);
                        end
                        default: ;
                    endcase
                end
                ST_RS1: if (tick) begin scl_l <= 1'b0; st <= ST_RS2; end
                ST_RS2: if (tick) begin sda_l <= 1'b1; rep <= 1'b1; st <= ST_STA; end
                ST_STA: if (tick) begin
                    scl_l <= 1'b1; st <= ST_HOLD; is_addr <= 1'b1;
                    done <= 1'b1; code <= rep ? SC_RSTART : SC_START;
                end
                ST_BLO: if (tick) begin scl_l <= 1'b0; st <= ST_BHI; end
                ST_BHI: if (tick) begin
                    if (lost) begin
                        scl_l <= 1'b0; sda_l <= 1'b0; st <= ST_IDLE;
                        is_addr <= 1'b0; done <= 1'b1; code <= SC_ARB;
                    end else if (idx == 4'd8) begin
                        scl_l <= 1'b1; sda_l <= 1'b0; st <= ST_HOLD;
                        done <= 1'b1; code <= byte_code(is_addr, is_rd, !sda_in);
                        is_addr <= 1'b0;
                        if (!mtx) begin rx_load <= 1'b1; rx_byte <= sh; end
                    end else begin
                        sh    <= {sh[6:0], sda_in};
                        idx   <= idx + 4'd1;
                        scl_l <= 1'b1;
                        st    <= ST_BLO;
                        sda_l <= bit_pull(mtx, idx + 4'd1, sh[6], ack_en);
                    end
                end
                ST_SP1: if (tick) begin scl_l <= 1'b0; st <= ST_SP2; end
                ST_SP2: if (tick) begin sda_l <= 1'b0; st <= ST_SP3; end
                ST_SP3: if (tick) begin
                    st <= ST_IDLE; is_addr <= 1'b0; stop_done <= 1'b1;
                end
                default: st <= ST_IDLE;
            endcase
        end
    end

    AST_SDA_STILL_SCL_HIGH: assert property (@(posedge clk) disable iff (rst)
        (st == ST_BHI && $past(st) == ST_BHI) |-> $stable(sda_q)); // R6

    AST_ARB_RELEASE: assert property (@(posedge clk) disable iff (rst)
        lost |=> (!scl_l && !sda_l && st == ST_IDLE)); // R12

endmodule

// File: rtl/i2c_host_engine.sv
module i2c_host_engine
    import i2c_hm_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_we,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq,
    input  logic       scl_in,
    input  logic       sda_in,
    output logic       scl_oe,
    output logic       sda_oe
);
    ctrl_t            cr;
    logic [4:0]       code5;
    logic [1:0]       psc;
    logic [DIV_W-1:0] rate;
    logic [7:0]       dreg;

    logic       run, stall, tick, eng_done, rx_load, stop_done;
    logic [4:0] eng_code;
    logic [7:0] rx_byte;
    eng_cmd_t   cmd;

    logic wr_ctrl, wr_stat, wr_rate, wr_data, launch;
    assign wr_ctrl = reg_we && (reg_addr == RA_CTRL);
    assign wr_stat = reg_we && (reg_addr == RA_STAT);
    assign wr_rate = reg_we && (reg_addr == RA_RATE);
    assign wr_data = reg_we && (reg_addr == RA_DATA);
    assign launch  = wr_ctrl && reg_wdata[7] && reg_wdata[2];

    always_comb begin
        if (!launch)          cmd = CMD_NONE;
        else if (reg_wdata[5]) cmd = CMD_START;
        else if (reg_wdata[4]) cmd = CMD_STOP;
        else                   cmd = CMD_BYTE;
    end

    i2c_hm_timer #(.DIV_W(DIV_W)) u_timer (
        .clk(clk), .rst(rst), .run(run), .stall(stall),
        .div(rate), .psc(psc), .tick(tick)
    );

    i2c_hm_fsm u_fsm (
        .clk(clk), .rst(rst), .tick(tick), .cmd(cmd), .tx_byte(dreg),
        .ack_en(cr.ack_en), .sda_in(sda_in), .scl_in(scl_in),
        .run(run), .stall(stall), .scl_low(scl_oe), .sda_low(sda_oe),
        .done(eng_done), .code(eng_code), .rx_load(rx_load),
        .rx_byte(rx_byte), .stop_done(stop_done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cr    <= '0;
            code5 <= SC_IDLE;
            psc   <= '0;
            rate  <= '0;
            dreg  <= '0;
        end else begin
            if (wr_ctrl) begin
                cr.ack_en    <= reg_wdata[6];
                cr.req_start <= reg_wdata[5];
                cr.req_stop  <= reg_wdata[4];
                cr.enable    <= reg_wdata[2];
                cr.irq_en    <= reg_wdata[0];
                if (reg_wdata[7]) cr.done_f <= 1'b0;
            end
            if (wr_stat) psc  <= reg_wdata[1:0];
            if (wr_rate) rate <= DIV_W'(reg_wdata);
            if (wr_data) begin
                if (cr.done_f) begin
                    dreg    <= reg_wdata;
                    cr.wcol <= 1'b0;
                end else begin
                    cr.wcol <= 1'b1;
                end
            end
            if (eng_done) begin
                cr.done_f <= 1'b1;
                code5     <= eng_code;
                if (rx_load) dreg <= rx_byte;
            end
            if (stop_done) begin
                cr.req_stop <= 1'b0;
                code5       <= SC_IDLE;
            end
        end
    end

    always_comb begin
        case (reg_addr)
            RA_CTRL: reg_rdata = {cr.done_f, cr.ack_en, cr.req_start, cr.req_stop,
                                  cr.wcol, cr.enable, 1'b0, cr.irq_en};
            RA_STAT: reg_rdata = {code5, 1'b0, psc};
            RA_RATE: reg_rdata = 8'(rate);
            default: reg_rdata = dreg;
        endcase
    end

    assign irq = cr.done_f && cr.irq_en && cr.enable;

    AST_WCOL_HOLDS_DATA: assert property (@(posedge clk) disable iff (rst)
        (wr_data && !cr.done_f && !eng_done) |=> $stable(dreg)); // R11

    AST_DONE_RAISES_FLAG: assert property (@(posedge clk) disable iff (rst)
        eng_done |=> cr.done_f); // R9

    AST_LAUNCH_CLEARS_FLAG: assert property (@(posedge clk) disable iff (rst)
        (launch && !eng_done) |=> !cr.done_f); // R9

    AST_STOP_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
        stop_done |=> (!cr.req_stop && !cr.done_f)); // R10

endmodule

// File: tb/i2c_host_engine_test.sv
`timescale 1ns/1ps
module i2c_host_engine_test;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_we = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic       irq, scl_in, sda_in, scl_oe, sda_oe;

    int vectors = 0;
    int fails = 0;

    always #2.5 clk = ~clk;  // 200 MHz

    // open-drain wires: engine, target model and a second driver
    logic s_pull = 1'b0;
    logic x_pull = 1'b0;
    assign scl_in = !scl_oe;
    assign sda_in = !(sda_oe || s_pull || x_pull);

    i2c_host_engine uut (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
        .scl_in(scl_in), .sda_in(sda_in), .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    // ---------------- behavioural bus target ----------------
    int         s_bit = -1;
    logic [7:0] s_sh = 8'd0, s_tx_byte = 8'd0, last_rx = 8'd0;
    logic       s_first = 1'b0, s_tx = 1'b0, m_ack = 1'b0, slave_ack = 1'b1;
    int         arb_k = -1;
    int         starts = 0, stops = 0;
    realtime    prev_rise = 0, period = 0;

    always @(negedge sda_in) if (scl_in === 1'b1) begin
        s_bit = -1; s_first = 1'b1; s_tx = 1'b0; s_pull = 1'b0; starts++;
    end
    always @(posedge sda_in) if (scl_in === 1'b1) stops++;

    always @(posedge scl_in) begin
        period = $realtime - prev_rise;
        prev_rise = $realtime;
        if (s_bit >= 0 && s_bit < 8) s_sh = {s_sh[6:0], sda_in};
        else if (s_bit == 8 && s_tx) m_ack = !sda_in;
    end

    always @(negedge scl_in) begin
        s_bit++;
        if (s_bit == 9) begin
            s_bit = 0;
            if (s_first) begin s_first = 1'b0; s_tx = s_sh[0] && slave_ack; end
            else if (s_tx && !m_ack) s_tx = 1'b0;
            s_pull = s_tx && !s_tx_byte[7];
        end else if (s_bit == 8) begin
            if (!s_tx) begin last_rx = s_sh; s_pull = slave_ack; end
            else s_pull = 1'b0;
        end else if (s_bit > 0) begin
            s_pull = s_tx && !s_tx_byte[7 - s_bit];
        end else begin
            s_pull = 1'b0;
        end
        if (arb_k >= 0 && s_bit == arb_k) x_pull = 1'b1;
    end

    // ---------------- helpers ----------------
    function automatic real exp_period(input int div, input int psc);
        return real'(16 + 2 * div * (1 << (2 * psc))) * 5.0;
    endfunction

    function automatic logic [7:0] exp_addr_code(input logic rd, input logic ack);
        if (rd) return ack ? 8'h40 : 8'h48;
        return ack ? 8'h18 : 8'h20;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_we = 1'b1;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_done();
        logic [7:0] c;
        int n = 0;
        do begin rd(2'd0, c); n++; end while (!c[7] && n < 40000);
        chk("R9 step completes", {31'd0, c[7]}, 32'd1);
    endtask

    task automatic wait_stop();
        logic [7:0] c;
        int n = 0;
        do begin rd(2'd0, c); n++; end while (c[4] && n < 40000);
        chk("R10 stop request self-clears", {31'd0, c[4]}, 32'd0);
        chk("R10 done stays low after stop", {31'd0, c[7]}, 32'd0);
    endtask

    task automatic do_stop(input logic [7:0] ie, input logic [1:0] psc);
        logic [7:0] s;
        int sp0 = stops;
        wr(2'd0, 8'h94 | ie);
        wait_stop();
        rd(2'd1, s);
        chk("R10 status after stop", s, {8'hF8 | 8'(psc)});
        chk("R10 stop edge on bus", stops, sp0 + 1);
        chk("R10 lines released", {30'd0, scl_oe, sda_oe}, 32'd0);
    endtask

    task automatic run_txn(input int div, input int psc, input logic [7:0] ie);
        logic [7:0] s, c, a, d, tb;
        logic sa, da;
        int st0, sp0;
        wr(2'd2, 8'(div));
        wr(2'd1, 8'(psc));
        slave_ack = 1'b1;
        st0 = starts;
        wr(2'd0, 8'hA4 | ie);
        wait_done();
        rd(2'd1, s);
        chk("R4 start code", s, {8'h08 | 8'(psc)});
        chk("R4 start edge", starts, st0 + 1);
        chk("R13 irq follows done and enables", {31'd0, irq}, {31'd0, ie[0]});
        // address, write direction
        a = {7'($urandom), 1'b0};
        sa = 1'($urandom);
        slave_ack = sa;
        wr(2'd3, a);
        rd(2'd0, c);
        chk("R11 wcol clear on accepted write", {31'd0, c[3]}, 32'd0);
        st0 = starts; sp0 = stops;
        wr(2'd0, 8'h84 | ie);
        wait_done();
        rd(2'd1, s);
        chk("R6 write address code", s, {exp_addr_code(1'b0, sa) | 8'(psc)});
        chk("R6 address bits MSB first", last_rx, a);
        chk("R6 no START or STOP inside byte", starts + stops, st0 + sp0);
        vectors++;
        if (period != exp_period(div, psc)) begin
            fails++;
            $display("FAIL R3 scl period: actual %0f expected %0f", period, exp_period(div, psc));
        end
        if (sa) begin
            d = 8'($urandom);
            da = 1'($urandom);
            slave_ack = da;
            wr(2'd3, d);
            wr(2'd0, 8'h84 | ie);
            wait_done();
            rd(2'd1, s);
            chk("R7 data write code", s, {(da ? 8'h28 : 8'h30) | 8'(psc)});
            chk("R7 data byte on bus", last_rx, d);
        end
        // repeated start, read direction
        slave_ack = 1'b1;
        wr(2'd0, 8'hA4 | ie);
        wait_done();
        rd(2'd1, s);
        chk("R5 repeated start code", s, {8'h10 | 8'(psc)});
        tb = 8'($urandom);
        s_tx_byte = tb;
        wr(2'd3, a | 8'h01);
        wr(2'd0, 8'h84 | ie);
        wait_done();
        rd(2'd1, s);
        chk("R6 read address code", s, {8'h40 | 8'(psc)});
        wr(2'd0, 8'hC4 | ie);
        wait_done();
        rd(2'd1, s);
        chk("R8 read with ACK code", s, {8'h50 | 8'(psc)});
        rd(2'd3, d);
        chk("R8 received byte", d, tb);
        chk("R8 master drove ACK", {31'd0, m_ack}, 32'd1);
        wr(2'd0, 8'h84 | ie);
        wait_done();
        rd(2'd1, s);
        chk("R8 read with NACK code", s, {8'h58 | 8'(psc)});
        rd(2'd3, d);
        chk("R8 second received byte", d, tb);
        chk("R8 master left NACK", {31'd0, m_ack}, 32'd0);
        do_stop(ie, 2'(psc));
    endtask

    // ---------------- watchdog ----------------
    initial begin
        #(200000 * 5);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    // ---------------- main sequence ----------------
    initial begin
        logic [7:0] v, s;
        int st0, sp0;
        void'($urandom(32'd1357));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        rd(2'd0, v); chk("R1 control after reset", v, 8'h00);
        rd(2'd1, v); chk("R1 status after reset", v, 8'hF8);
        chk("R1 irq and lines after reset", {29'd0, irq, scl_oe, sda_oe}, 32'd0);
        // R2 register map
        wr(2'd1, 8'hFF); rd(2'd1, v); chk("R2 only prescale writable", v, 8'hFB);
        wr(2'd2, 8'h5A); rd(2'd2, v); chk("R2 bit rate readback", v, 8'h5A);
        wr(2'd0, 8'h41); rd(2'd0, v); chk("R2 control layout", v, 8'h41);
        wr(2'd1, 8'h00); wr(2'd2, 8'h01);
        // R9 no launch without bit 7
        st0 = starts;
        wr(2'd0, 8'h24);
        repeat (60) @(negedge clk);
        chk("R9 write without bit 7 launches nothing", {30'd0, scl_oe, sda_oe}, 32'd0);
        chk("R9 no START without bit 7", starts, st0);
        // R11 collision while done is low
        wr(2'd3, 8'h3C);
        rd(2'd0, v); chk("R11 collision flag set", {31'd0, v[3]}, 32'd1);
        rd(2'd3, v); chk("R11 data unchanged on collision", v, 8'h00);
        // R9 START wins over STOP; read address refused
        sp0 = stops;
        wr(2'd0, 8'hB4);
        wait_done();
        rd(2'd1, s);
        chk("R9 START has priority over STOP", s, 8'h08);
        chk("R9 no STOP issued", stops, sp0);
        slave_ack = 1'b0;
        wr(2'd3, 8'hA5);
        wr(2'd0, 8'h84);
        wait_done();
        rd(2'd1, s);
        chk("R6 read address NACK code", s, 8'h48);
        do_stop(8'h00, 2'd0);
        // R12 arbitration loss at bit 2
        slave_ack = 1'b1;
        wr(2'd0, 8'hA4);
        wait_done();
        wr(2'd3, 8'hFE);
        arb_k = 2;
        wr(2'd0, 8'h84);
        wait_done();
        rd(2'd1, s);
        chk("R12 arbitration lost code", s, 8'h38);
        chk("R12 lines released", {30'd0, scl_oe, sda_oe}, 32'd0);
        arb_k = -1;
        x_pull = 1'b0;
        repeat (4) @(negedge clk);
        // R3 high prescaler settings
        run_txn(1, 2, 8'h01);
        run_txn(1, 3, 8'h00);
        // random mix
        for (int i = 0; i < 6; i++)
            run_txn(int'($urandom % 7), int'($urandom % 2), 8'($urandom % 2));
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule